// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host port and an external asynchronous static RAM that is 32 bits wide. The RAM has four active-low chip enables, one per byte lane, plus a shared active-low write strobe and a shared active-low output enable. The host hands over one request at a time through a valid/ready handshake. Each request carries an address, write data, a 4-bit byte mask and a read/write flag. The controller then plays out a fixed setup, strobe and hold sequence on the RAM pins. The length of each phase is a whole number of clocks set by a parameter, so the sequence can be matched to the RAM's access time and minimum write pulse.

Because each byte lane has its own chip enable, the enables do the work of a byte mask. The same enables let the part be used at half width and twice the depth. A static mode input selects full-word operation or half-word operation. In half-word mode the lowest host address bit chooses the lane pair, and half-word reads come back right-aligned. The data bus is driven only during a write strobe. A later read's output enable always comes after at least one cycle with the bus released.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `req_ready` is 1, `ram_ce_n` is 4'hF, `ram_we_n` and `ram_oe_n` are 1, `ram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: `ram_we_n` and `ram_oe_n` are never low together, and `ram_dq_oe` is 1 exactly in the cycles where `ram_we_n` is 0.
- R3: `ram_oe_n` falls only when `ram_dq_oe` was 0 in the cycle before.
- R4: An accepted request runs three phases. First come SETUP_CYC cycles with the selected enables low and both strobes high. Then come STROBE_CYC cycles with the strobe low (`ram_we_n` for a write, `ram_oe_n` for a read). Last come HOLD_CYC cycles with the enables low and both strobes high. `ram_addr` stays stable while any enable is low, and `req_ready` is 0 until the sequence ends.
- R5: In full mode, a write pulls `ram_ce_n[i]` low only where `req_mask[i]` is 1. Lane i carries data bits 8i+7:8i, so lane 0 is bits 7:0 and lane 3 is bits 31:24. Lanes that are not selected keep their RAM contents, and a write with mask 4'h0 changes nothing.
- R6: A full-mode read enables all four lanes and returns the 32-bit word on `rsp_rdata`. `rsp_valid` is a one-cycle pulse that appears exactly SETUP_CYC+STROBE_CYC clock edges after the edge that accepted the request.
- R7: In half mode (`half_mode`=1) the RAM address is `req_addr[ADDR_W:1]`. `req_addr[0]`=0 selects lanes 0 and 1, and `req_addr[0]`=1 selects lanes 2 and 3. No lane outside the selected pair is ever enabled.
- R8: A half-mode write places `req_wdata[15:0]` on the selected pair. `req_mask[0]` enables the pair's lower byte and `req_mask[1]` its upper byte. `req_mask[3:2]` are ignored.
- R9: A half-mode read returns the selected half-word in `rsp_rdata[15:0]`, with `rsp_rdata[31:16]` equal to zero.
- R10: In full mode the RAM address is `req_addr[ADDR_W-1:0]`, and `req_addr[ADDR_W]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_mode | input | 1 | 1 selects half-word operation; change only while idle |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W+1 | Host address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte mask for writes |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 32 | Read data |
| ram_addr | output | ADDR_W | RAM word address |
| ram_ce_n | output | 4 | Per-lane chip enables, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | 32 | Data toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_out` |
| ram_dq_in | input | 32 | Data from the RAM |

## Verification
A host can issue a read right after a write, and then two things can fall in the same cycle: the write's data drive is released, and the read's output enable is asserted. The bench provokes this by issuing the read on the first cycle that `req_ready` returns after a write. A monitor then flags any cycle in which the output enable goes low while the bus was driven one cycle earlier, or in which both strobes are low at once. The read data returned in that same transfer must equal the word just written.

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_mask,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [3:0]        ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [31:0]       ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [31:0]       ram_dq_in
);

  localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
  localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic               wr_q, half_q, upper_q;
  logic [3:0]         lanes_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [31:0]        wdata_q;

  logic        accept, last;
  logic [3:0]  pair, mask_eff, lanes_d;

  assign accept   = req_valid && (st == S_IDLE);
  assign last     = (cnt == '0);
  assign pair     = !half_mode ? 4'hF : (req_addr[0] ? 4'hC : 4'h3);
  assign mask_eff = half_mode ? {req_mask[1:0], req_mask[1:0]} : req_mask;
  assign lanes_d  = req_write ? (pair & mask_eff) : pair;

  assign req_ready  = (st == S_IDLE);
  assign ram_addr   = addr_q;
  assign ram_ce_n   = (st == S_IDLE) ? 4'hF : ~lanes_q;
  assign ram_we_n   = !((st == S_STROBE) && wr_q);
  assign ram_oe_n   = !((st == S_STROBE) && !wr_q);
  assign ram_dq_oe  = (st == S_STROBE) && wr_q;
  assign ram_dq_out = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      half_q  <= 1'b0;
      upper_q <= 1'b0;
      lanes_q <= 4'h0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_SETUP;
          cnt     <= CNT_W'(SETUP_CYC - 1);
          wr_q    <= req_write;
          half_q  <= half_mode;
          upper_q <= half_mode && req_addr[0];
          lanes_q <= lanes_d;
          addr_q  <= half_mode ? req_addr[ADDR_W:1] : req_addr[ADDR_W-1:0];
          wdata_q <= half_mode ? {2{req_wdata[15:0]}} : req_wdata;
        end
        S_SETUP: if (last) begin
          st  <= S_STROBE;
          cnt <= CNT_W'(STROBE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_STROBE: if (last) begin
          st  <= S_HOLD;
          cnt <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        default: if (last) st <= S_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (st == S_STROBE) && last && !wr_q;
      if ((st == S_STROBE) && last && !wr_q)
        rsp_rdata <= upper_q ? {16'h0, ram_dq_in[31:16]} :
                     half_q  ? {16'h0, ram_dq_in[15:0]}  : ram_dq_in;
    end
  end

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
  parameter int ADDR_W     = 8,
  parameter int STROBE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              half_mode,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [3:0]        ram_ce_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_dq_oe
);

  logic [7:0] we_run;
  always_ff @(posedge clk) begin
    if (!rst_n) we_run <= '0;
    else if (ram_we_n) we_run <= '0;
    else if (we_run != 8'hFF) we_run <= we_run + 1'b1;
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n == 4'hF && ram_we_n && ram_oe_n && !ram_dq_oe));

  // R2
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_we_n && !ram_oe_n));

  // R2
  drive_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe == !ram_we_n);

  // R3
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_oe_n) |-> !$past(ram_dq_oe));

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_run >= 8'(STROBE_CYC)));

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_ce_n != 4'hF && $past(ram_ce_n) != 4'hF) |-> $stable(ram_addr));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_mode |-> (ram_ce_n[3:2] == 2'b11 || ram_ce_n[1:0] == 2'b11));

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
  .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_dq_oe(ram_dq_oe));

// File: tb/async_sram_ctrl_bench.sv
module async_sram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int SETUP_CYC = 2, STROBE_CYC = 3, HOLD_CYC = 1;

  logic clk = 0, rst_n = 0, half_mode = 0;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_mask = '0;
  logic req_ready, rsp_valid, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [31:0] rsp_rdata, ram_dq_out, ram_dq_in;
  logic [ADDR_W-1:0] ram_addr;
  logic [3:0] ram_ce_n;

  int checks = 0, errors = 0, mon_viol = 0;
  logic [3:0] seen_lanes = 0;
  logic [31:0] mem [0:(1<<ADDR_W)-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  async_sram_ctrl #(.ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
                    .HOLD_CYC(HOLD_CYC)) u_async_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in));

  always_comb
    for (int l = 0; l < 4; l++)
      ram_dq_in[8*l +: 8] = (!ram_ce_n[l] && !ram_oe_n && ram_we_n) ? mem[ram_addr][8*l +: 8] : 8'hA5;

  always @(posedge clk)
    if (!ram_we_n && ram_dq_oe)
      for (int l = 0; l < 4; l++)
        if (!ram_ce_n[l]) mem[ram_addr][8*l +: 8] <= ram_dq_out[8*l +: 8];

  int we_run = 0;
  logic prev_dq_oe = 0, prev_oe_n = 1;
  always @(negedge clk) if (rst_n) begin
    seen_lanes = seen_lanes | ~ram_ce_n;
    if (!ram_we_n && !ram_oe_n) mon_viol++;
    if (!ram_oe_n && prev_oe_n && prev_dq_oe) mon_viol++;
    if (ram_we_n && we_run != 0 && we_run < STROBE_CYC) mon_viol++;
    we_run = ram_we_n ? 0 : we_run + 1;
    prev_dq_oe = ram_dq_oe;
    prev_oe_n = ram_oe_n;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [ADDR_W:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    seen_lanes = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [ADDR_W:0] a, input logic [31:0] d, input logic [3:0] m);
    issue(1, a, d, m);
    wait_idle();
  endtask

  task automatic do_read(input logic [ADDR_W:0] a, output logic [31:0] d, output int lat);
    issue(0, a, 0, 0);
    lat = 0;
    while (lat < 50) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (rsp_valid) break;
    end
    d = rsp_rdata;
    @(negedge clk);
    check(!rsp_valid, "R6 pulse width", {31'd0, rsp_valid}, 0);
    wait_idle();
  endtask

  task automatic t_reset();
    check(req_ready == 1, "R1 ready", {31'd0, req_ready}, 1);
    check(ram_ce_n == 4'hF, "R1 ce", {28'd0, ram_ce_n}, 32'hF);
    check(ram_we_n && ram_oe_n, "R1 strobes", {30'd0, ram_we_n, ram_oe_n}, 3);
    check(!ram_dq_oe && !rsp_valid, "R1 drive/rsp", {30'd0, ram_dq_oe, rsp_valid}, 0);
  endtask

  task automatic t_full();
    logic [31:0] d; int lat;
    do_write(9'h005, 32'h11223344, 4'hF);
    check(mem[5] == 32'h11223344, "R5 full write", mem[5], 32'h11223344);
    do_read(9'h005, d, lat);
    check(d == 32'h11223344, "R6 read data", d, 32'h11223344);
    check(lat == SETUP_CYC + STROBE_CYC, "R6 latency", lat, SETUP_CYC + STROBE_CYC);
    check(seen_lanes == 4'hF, "R6 all lanes", {28'd0, seen_lanes}, 32'hF);
    do_read(9'h105, d, lat);
    check(d == 32'h11223344, "R10 top addr bit ignored", d, 32'h11223344);
  endtask

  task automatic t_mask();
    do_write(9'h005, 32'hAABBCCDD, 4'b0101);
    check(mem[5] == 32'h11BB33DD, "R5 masked write", mem[5], 32'h11BB33DD);
    check(seen_lanes == 4'b0101, "R5 lanes", {28'd0, seen_lanes}, 32'h5);
    do_write(9'h005, 32'hFFFFFFFF, 4'h0);
    check(mem[5] == 32'h11BB33DD, "R5 empty mask", mem[5], 32'h11BB33DD);
    check(seen_lanes == 4'h0, "R5 empty lanes", {28'd0, seen_lanes}, 0);
  endtask

  task automatic t_timing();
    bit ok = 1;
    issue(1, 9'h009, 32'h0BADF00D, 4'b1010);
    for (int k = 0; k < SETUP_CYC; k++) begin
      if (!(ram_ce_n == 4'b0101 && ram_we_n && ram_oe_n && !req_ready)) ok = 0;
      @(negedge clk);
    end
    for (int k = 0; k < STROBE_CYC; k++) begin
      if (!(ram_ce_n == 4'b0101 && !ram_we_n && ram_dq_oe && ram_addr == 8'h09)) ok = 0;
      @(negedge clk);
    end
    for (int k = 0; k < HOLD_CYC; k++) begin
      if (!(ram_ce_n == 4'b0101 && ram_we_n && ram_oe_n)) ok = 0;
      @(negedge clk);
    end
    check(ok, "R4 phase sequence", {31'd0, ok}, 1);
    check(req_ready && ram_ce_n == 4'hF, "R4 back to idle", {27'd0, req_ready, ram_ce_n}, 32'h1F);
    check(mem[9] == 32'h0B09F009, "R5 lanes 1,3 written", mem[9], 32'h0B09F009);
  endtask

  task automatic t_half();
    logic [31:0] d; int lat;
    half_mode = 1;
    do_write(9'h00E, 32'h1234BEEF, 4'h3);
    check(mem[7] == 32'h0707BEEF, "R8 lower pair write", mem[7], 32'h0707BEEF);
    check(seen_lanes == 4'b0011, "R7 lower pair lanes", {28'd0, seen_lanes}, 3);
    do_write(9'h00F, 32'h5678CAFE, 4'b1101);
    check(mem[7] == 32'h07FEBEEF, "R8 upper pair, mask[3:2] ignored", mem[7], 32'h07FEBEEF);
    check(seen_lanes == 4'b0100, "R7 upper pair lanes", {28'd0, seen_lanes}, 4);
    do_read(9'h00F, d, lat);
    check(d == 32'h000007FE, "R9 upper read shifted", d, 32'h000007FE);
    check(seen_lanes == 4'b1100, "R7 read pair", {28'd0, seen_lanes}, 32'hC);
    do_read(9'h00E, d, lat);
    check(d == 32'h0000BEEF, "R9 lower read", d, 32'h0000BEEF);
    half_mode = 0;
  endtask

  task automatic t_b2b();
    logic [31:0] d; int lat;
    do_write(9'h020, 32'hDEADC0DE, 4'hF);
    do_read(9'h020, d, lat);
    check(d == 32'hDEADC0DE, "R3 read right after write", d, 32'hDEADC0DE);
    check(mon_viol == 0, "R2/R3/R4 strobe monitor", mon_viol, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = {4{8'(i)}};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full();
    t_mask();
    t_timing();
    t_half();
    t_b2b();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule